// File: doc/BRIEF.md
# DRAM Refresh and Low-Power Manager

This block keeps a DDR SDRAM refreshed and moves it in and out of its two low-power states. A down-counter, loaded from a 16-bit refresh interval, flags when a refresh is owed. The block then asks the shared command bus for a slot. Once the slot is granted, it drives one AUTO REFRESH and holds the bus idle for the programmed refresh recovery time. The grant also tells the block that every bank is already precharged.

A user command toggles each low-power state. Code 101 enters and leaves power-down, and code 110 enters and leaves self-refresh. While the memory sleeps in power-down, the block still serves each due refresh on its own: it raises the clock enable, refreshes, and lowers the clock enable again. In self-refresh the memory refreshes itself, so the block stays silent. A refresh that falls due meanwhile is served as soon as the block is ready again.

The state machine has these states:

| State | Meaning |
|---|---|
| `S_IDLE` | Active and ready |
| `S_REQ` | Asking for the bus before a refresh |
| `S_REF` | AUTO REFRESH cycle |
| `S_TRFC` | Refresh recovery wait |
| `S_PD` | Power-down |
| `S_PD_WAKE` | Clock enable raised for a refresh during power-down |
| `S_PD_EXIT` | One settling cycle after power-down |
| `S_SR_REQ` | Asking for the bus before self-refresh |
| `S_SR_ENTER` | Self-refresh entry cycle |
| `S_SR` | Self-refresh |
| `S_SR_EXIT` | Settling wait after self-refresh |

The transitions are:

- `S_IDLE` goes to `S_PD` on code 101, to `S_SR_REQ` on code 110, and otherwise to `S_REQ` when a refresh is due. The user command takes priority over a due refresh.
- `S_REQ` goes to `S_REF` on grant.
- `S_REF` goes to `S_TRFC`.
- `S_TRFC` goes, once the wait has elapsed, back to `S_PD` if the refresh began in power-down, and otherwise to `S_IDLE`.
- `S_PD` goes to `S_PD_EXIT` on code 101, and otherwise to `S_PD_WAKE` when a refresh is due.
- `S_PD_WAKE` goes to `S_REQ`.
- `S_PD_EXIT` goes to `S_IDLE`.
- `S_SR_REQ` goes to `S_SR_ENTER` on grant.
- `S_SR_ENTER` goes to `S_SR`.
- `S_SR` goes to `S_SR_EXIT` on code 110.
- `S_SR_EXIT` goes to `S_IDLE` once its wait has elapsed.

Top module: `dram_refresh_pm`

## Requirements
- R1: After reset the block is idle:
  - `cke` is 1.
  - `bus_cmd` (bits {CS#, RAS#, CAS#, WE#}) is NOP = 4'b0111.
  - `bus_req` is 0 and `busy` is 0.
  - `lp_mode` is 2'b00 (active). The other encodings are 2'b01 for power-down and 2'b10 for self-refresh.
- R2: In the active state with `bus_grant` held high, AUTO REFRESH (`bus_cmd` = 4'b0001) repeats every `refresh_period`+3 cycles.
- R3: Before each AUTO REFRESH and each self-refresh entry, `bus_req` rises and stays high until `bus_grant` is seen. The command appears in the cycle after `bus_req` and `bus_grant` are both high, and never while the grant is withheld.
- R4: In the `trfc_cycles` cycles after an AUTO REFRESH issued with `cke` high:
  - `bus_cmd` is NOP and `bus_req` stays high.
  - In the following cycle `bus_req` is low again.
  - No second AUTO REFRESH comes sooner.
- R5: Code 101 while idle makes `cke` low with NOP on the bus in the next cycle, and `lp_mode` becomes 2'b01.
- R6: In power-down or self-refresh, every command except the one that exits that state leaves `cke` and `lp_mode` unchanged and produces no bus command.
- R7: A refresh that falls due in power-down is carried out as follows:
  - `cke` rises for one NOP cycle, and the block then requests the bus.
  - AUTO REFRESH is issued with `cke` high and `lp_mode` 2'b01, `refresh_period`+4 cycles after the previous refresh.
  - After `trfc_cycles` NOP cycles, `cke` is low again with `lp_mode` 2'b01.
- R8: Code 101 in power-down gives one NOP cycle with `cke` high and `busy` high. After that cycle the block is ready, with `busy` 0 and `lp_mode` 2'b00.
- R9: Code 110 while idle raises `bus_req`. On grant, AUTO REFRESH is driven in the same cycle that `cke` falls, and from the next cycle `lp_mode` is 2'b10.
- R10: In self-refresh no AUTO REFRESH is issued and `cke` stays low, even when the refresh interval expires.
- R11: Code 110 in self-refresh raises `cke`. Exactly `SR_EXIT_CYCLES` (200) NOP cycles then pass with `busy` high before `busy` falls and `lp_mode` returns to 2'b00.
- R12: A refresh that fell due during self-refresh is requested in the first cycle after the block reports ready. With the grant high, AUTO REFRESH follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_cmd | input | 3 | User command code; 101 toggles power-down, 110 toggles self-refresh, others ignored |
| refresh_period | input | PERIOD_W | Cycles between refreshes |
| trfc_cycles | input | TRFC_W | Refresh recovery time in cycles |
| bus_grant | input | 1 | Command bus granted, all banks precharged |
| cke | output | 1 | Clock enable to the memory |
| bus_cmd | output | 4 | {CS#, RAS#, CAS#, WE#} command word |
| bus_req | output | 1 | Request for the command bus |
| busy | output | 1 | User commands are not acted on |
| lp_mode | output | 2 | 00 active, 01 power-down, 10 self-refresh |

## Verification
The assertions assume the following about the inputs:

- `trfc_cycles` and `refresh_period` stay constant while a refresh is in flight.
- The refresh period is longer than the recovery time plus the wake overhead.
- The grant is a level that the sequencer raises only when it can hand over an idle, fully precharged bus.

The bench programs the timing values once after reset and never changes them. It drives each user command as a single-cycle pulse, and it lowers the grant only while no refresh is being issued, so that it can show that the request is held. It issues the exit commands only when `busy` is low.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REQ,
        S_REF,
        S_TRFC,
        S_PD,
        S_PD_WAKE,
        S_PD_EXIT,
        S_SR_REQ,
        S_SR_ENTER,
        S_SR,
        S_SR_EXIT
    } rpm_state_e;

    localparam logic [2:0] UCMD_PWRDN   = 3'b101;
    localparam logic [2:0] UCMD_SELFREF = 3'b110;

    // {CS#, RAS#, CAS#, WE#}
    localparam logic [3:0] BUS_NOP  = 4'b0111;
    localparam logic [3:0] BUS_AREF = 4'b0001;

    localparam logic [1:0] MODE_ACT = 2'b00;
    localparam logic [1:0] MODE_PD  = 2'b01;
    localparam logic [1:0] MODE_SR  = 2'b10;

endpackage

// File: rtl/rpm_refresh_timer.sv
module rpm_refresh_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    input  logic                reload,
    output logic                due
);

    logic [PERIOD_W-1:0] cnt_q;
    logic                armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (!armed_q || reload) begin
            cnt_q   <= period;
            armed_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign due = armed_q && (cnt_q == '0);

endmodule

// File: rtl/rpm_delay_counter.sv
module rpm_delay_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expiring
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expiring = (cnt_q <= W'(1));

endmodule

// File: rtl/rpm_fsm.sv
module rpm_fsm
    import rpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] usr_cmd,
    input  logic       due,
    input  logic       dly_expiring,
    input  logic       bus_grant,
    output logic       ld_trfc,
    output logic       ld_exit,
    output logic       ref_issued,
    output logic       cke,
    output logic [3:0] bus_cmd,
    output logic       bus_req,
    output logic       busy,
    output logic [1:0] lp_mode
);

    rpm_state_e state_q, state_d;
    logic       back_to_pd_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (usr_cmd == UCMD_PWRDN)        state_d = S_PD;
                else if (usr_cmd == UCMD_SELFREF) state_d = S_SR_REQ;
                else if (due)                     state_d = S_REQ;
            end
            S_REQ:      if (bus_grant) state_d = S_REF;
            S_REF:      state_d = S_TRFC;
            S_TRFC:     if (dly_expiring) state_d = back_to_pd_q ? S_PD : S_IDLE;
            S_PD: begin
                if (usr_cmd == UCMD_PWRDN) state_d = S_PD_EXIT;
                else if (due)              state_d = S_PD_WAKE;
            end
            S_PD_WAKE:  state_d = S_REQ;
            S_PD_EXIT:  state_d = S_IDLE;
            S_SR_REQ:   if (bus_grant) state_d = S_SR_ENTER;
            S_SR_ENTER: state_d = S_SR;
            S_SR:       if (usr_cmd == UCMD_SELFREF) state_d = S_SR_EXIT;
            S_SR_EXIT:  if (dly_expiring) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            back_to_pd_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_PD_WAKE)
                back_to_pd_q <= 1'b1;
            else if (state_q == S_TRFC && dly_expiring)
                back_to_pd_q <= 1'b0;
        end
    end

    always_comb begin
        cke        = 1'b1;
        bus_cmd    = BUS_NOP;
        bus_req    = 1'b0;
        busy       = 1'b1;
        lp_mode    = MODE_ACT;
        ld_trfc    = 1'b0;
        ld_exit    = 1'b0;
        ref_issued = 1'b0;
        unique case (state_q)
            S_IDLE: busy = 1'b0;
            S_REQ: begin
                bus_req = 1'b1;
                lp_mode = back_to_pd_q ? MODE_PD : MODE_ACT;
            end
            S_REF: begin
                bus_req    = 1'b1;
                bus_cmd    = BUS_AREF;
                ref_issued = 1'b1;
                ld_trfc    = 1'b1;
                lp_mode    = back_to_pd_q ? MODE_PD : MODE_ACT;
            end
            S_TRFC: begin
                bus_req = 1'b1;
                lp_mode = back_to_pd_q ? MODE_PD : MODE_ACT;
            end
            S_PD: begin
                cke     = 1'b0;
                busy    = 1'b0;
                lp_mode = MODE_PD;
            end
            S_PD_WAKE: lp_mode = MODE_PD;
            S_PD_EXIT: lp_mode = MODE_ACT;
            S_SR_REQ:  bus_req = 1'b1;
            S_SR_ENTER: begin
                bus_req    = 1'b1;
                cke        = 1'b0;
                bus_cmd    = BUS_AREF;
                ref_issued = 1'b1;
            end
            S_SR: begin
                cke     = 1'b0;
                busy    = 1'b0;
                lp_mode = MODE_SR;
                ld_exit = (usr_cmd == UCMD_SELFREF);
            end
            S_SR_EXIT: lp_mode = MODE_SR;
            default: busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/dram_refresh_pm.sv
module dram_refresh_pm #(
    parameter int PERIOD_W       = 16,
    parameter int TRFC_W         = 4,
    parameter int SR_EXIT_CYCLES = 200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          usr_cmd,
    input  logic [PERIOD_W-1:0] refresh_period,
    input  logic [TRFC_W-1:0]   trfc_cycles,
    input  logic                bus_grant,
    output logic                cke,
    output logic [3:0]          bus_cmd,
    output logic                bus_req,
    output logic                busy,
    output logic [1:0]          lp_mode
);
    import rpm_pkg::*;

    localparam int EXIT_W = $clog2(SR_EXIT_CYCLES + 1);
    localparam int DLY_W  = (EXIT_W > TRFC_W) ? EXIT_W : TRFC_W;
    localparam int RUN_W  = EXIT_W + 1;

    logic             due, dly_expiring, ld_trfc, ld_exit, ref_issued;
    logic [DLY_W-1:0] dly_val;

    assign dly_val = ld_exit ? DLY_W'(SR_EXIT_CYCLES) : DLY_W'(trfc_cycles);

    rpm_refresh_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (refresh_period),
        .reload (ref_issued),
        .due    (due)
    );

    rpm_delay_counter #(.W(DLY_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_trfc || ld_exit),
        .load_val (dly_val),
        .expiring (dly_expiring)
    );

    rpm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .usr_cmd      (usr_cmd),
        .due          (due),
        .dly_expiring (dly_expiring),
        .bus_grant    (bus_grant),
        .ld_trfc      (ld_trfc),
        .ld_exit      (ld_exit),
        .ref_issued   (ref_issued),
        .cke          (cke),
        .bus_cmd      (bus_cmd),
        .bus_req      (bus_req),
        .busy         (busy),
        .lp_mode      (lp_mode)
    );

    // Observation counters for the checks below
    logic [TRFC_W:0]  since_ar;
    logic [RUN_W-1:0] nop_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_ar <= '1;
        end else if (bus_cmd == BUS_AREF) begin
            since_ar <= '0;
        end else if (since_ar != '1) begin
            since_ar <= since_ar + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nop_run <= '0;
        end else if (!cke || bus_cmd != BUS_NOP) begin
            nop_run <= '0;
        end else if (nop_run != '1) begin
            nop_run <= nop_run + 1'b1;
        end
    end

    AST_AR_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == BUS_AREF) |-> $past(bus_req && bus_grant)); // R3

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant) |=> bus_req); // R3

    AST_TRFC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == BUS_AREF) |-> (since_ar >= {1'b0, trfc_cycles})); // R4

    AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> (bus_cmd == BUS_NOP)); // R10

    AST_SR_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == BUS_AREF && !cke) |=> (lp_mode == MODE_SR && !cke)); // R9

    AST_SR_EXIT_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode == MODE_ACT && $past(lp_mode) == MODE_SR)
            |-> (nop_run >= RUN_W'(SR_EXIT_CYCLES))); // R11

endmodule

// File: tb/test_dram_refresh_pm.sv
module test_dram_refresh_pm;

    localparam int P    = 40;
    localparam int TRFC = 5;
    localparam int SRX  = 200;
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] AR  = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  usr_cmd = 3'b000;
    logic [15:0] period = 16'(P);
    logic [3:0]  trfc = 4'(TRFC);
    logic        grant = 1'b1;
    logic        cke, bus_req, busy;
    logic [3:0]  bus_cmd;
    logic [1:0]  lp_mode;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_ar = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_pm i_dram_refresh_pm (
        .clk            (clk),
        .rst_n          (rst_n),
        .usr_cmd        (usr_cmd),
        .refresh_period (period),
        .trfc_cycles    (trfc),
        .bus_grant      (grant),
        .cke            (cke),
        .bus_cmd        (bus_cmd),
        .bus_req        (bus_req),
        .busy           (busy),
        .lp_mode        (lp_mode)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [2:0] c);
        usr_cmd = c;
        tick;
        usr_cmd = 3'b000;
    endtask

    task automatic wait_ar(input int lim, output int at);
        at = -1;
        for (int k = 0; k < lim; k++) begin
            tick;
            if (bus_cmd == AR) begin
                at = cyc;
                return;
            end
        end
    endtask

    task automatic t_reset;
        tick;
        check("R1 cke", int'(cke), 1);
        check("R1 bus_cmd", int'(bus_cmd), int'(NOP));
        check("R1 bus_req", int'(bus_req), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 lp_mode", int'(lp_mode), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_periodic;
        int a1, a2, bad;
        wait_ar(200, a1);
        check("R2 first refresh seen", int'(a1 >= 0), 1);
        bad = 0;
        for (int i = 0; i < TRFC; i++) begin
            tick;
            if (bus_cmd != NOP || !bus_req) bad++;
        end
        check("R4 NOP with request held during recovery", bad, 0);
        tick;
        check("R4 request released", int'(bus_req), 0);
        wait_ar(200, a2);
        check("R2 refresh spacing", a2 - a1, P + 3);
        last_ar = a2;
        repeat (TRFC + 1) tick;
    endtask

    task automatic t_grant_wait;
        int bad;
        grant = 1'b0;
        for (int k = 0; k < 200 && !bus_req; k++) tick;
        check("R3 request raised", int'(bus_req), 1);
        bad = 0;
        repeat (10) begin
            tick;
            if (bus_cmd == AR || !bus_req) bad++;
        end
        check("R3 no refresh while grant withheld", bad, 0);
        grant = 1'b1;
        tick;
        check("R3 refresh after grant", int'(bus_cmd), int'(AR));
        last_ar = cyc;
        repeat (TRFC + 1) tick;
    endtask

    task automatic t_pd_enter;
        check("R5 ready before entry", int'(busy), 0);
        pulse(3'b101);
        check("R5 cke low", int'(cke), 0);
        check("R5 NOP on entry", int'(bus_cmd), int'(NOP));
        check("R5 mode power-down", int'(lp_mode), 1);
        pulse(3'b110);
        pulse(3'b001);
        check("R6 cke stays low in power-down", int'(cke), 0);
        check("R6 mode kept in power-down", int'(lp_mode), 1);
        check("R6 no command in power-down", int'(bus_cmd), int'(NOP));
    endtask

    task automatic t_pd_refresh;
        int a, bad;
        wait_ar(200, a);
        check("R7 cke high at refresh", int'(cke), 1);
        check("R7 mode during refresh", int'(lp_mode), 1);
        check("R7 spacing in power-down", a - last_ar, P + 4);
        last_ar = a;
        bad = 0;
        for (int i = 0; i < TRFC; i++) begin
            tick;
            if (bus_cmd != NOP) bad++;
        end
        check("R7 NOP during recovery", bad, 0);
        tick;
        check("R7 cke low again", int'(cke), 0);
        check("R7 back in power-down", int'(lp_mode), 1);
    endtask

    task automatic t_pd_exit;
        pulse(3'b101);
        check("R8 cke high on exit", int'(cke), 1);
        check("R8 busy during exit cycle", int'(busy), 1);
        check("R8 NOP on exit", int'(bus_cmd), int'(NOP));
        tick;
        check("R8 ready", int'(busy), 0);
        check("R8 mode active", int'(lp_mode), 0);
    endtask

    task automatic t_sr_enter;
        int bad;
        grant = 1'b0;
        pulse(3'b110);
        check("R9 request for entry", int'(bus_req), 1);
        check("R9 cke still high", int'(cke), 1);
        bad = 0;
        repeat (3) begin
            tick;
            if (bus_cmd == AR || !bus_req) bad++;
        end
        check("R3 entry waits for grant", bad, 0);
        grant = 1'b1;
        tick;
        check("R9 refresh code on entry", int'(bus_cmd), int'(AR));
        check("R9 cke falls with entry", int'(cke), 0);
        tick;
        check("R9 mode self-refresh", int'(lp_mode), 2);
        check("R9 cke low", int'(cke), 0);
    endtask

    task automatic t_sr_quiet;
        int bad;
        pulse(3'b101);
        pulse(3'b001);
        check("R6 mode kept in self-refresh", int'(lp_mode), 2);
        bad = 0;
        repeat (120) begin
            tick;
            if (bus_cmd != NOP || cke) bad++;
        end
        check("R10 silent self-refresh", bad, 0);
    endtask

    task automatic t_sr_exit;
        int n;
        pulse(3'b110);
        check("R11 cke high on exit", int'(cke), 1);
        n = 0;
        while (busy && n < 1000) begin
            if (cke && bus_cmd == NOP) n++;
            tick;
        end
        check("R11 settle cycles", n, SRX);
        check("R11 mode active", int'(lp_mode), 0);
        tick;
        check("R12 pending refresh requested", int'(bus_req), 1);
        tick;
        check("R12 pending refresh issued", int'(bus_cmd), int'(AR));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset;
        t_periodic;
        t_grant_wait;
        t_pd_enter;
        t_pd_refresh;
        t_pd_exit;
        t_sr_enter;
        t_sr_quiet;
        t_sr_exit;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule